// File: doc/BRIEF.md
# Bidirectional Port with Per-Pin Function Sharing

This block is a general-purpose I/O port of up to eight pins. Four registers sit on a small synchronous bus: a port value register, a direction register, an alternate-function select register and a pull-up enable register. Each pin either drives its own latched value, drives a peripheral's output, or floats and is read back as an input. A build-time mask marks pins whose output stage can only pull low. On those pins a driven 1 releases the pad, so the pad can also be used as an input.

Every pad input is retimed through two flops. The retimed level is always sent to peripheral consumers such as interrupt or timer-clock logic, whatever the pin's direction. A read of the port value register returns a mix per pin. An input pin gives its retimed pad level. An output pin gives its latch contents, not the level on the pad. Reset sets every latch and every direction bit to 1, so the port comes up with all pins as inputs.

Top module: `gpio_port`

## Requirements
- R1: During and after synchronous reset, the direction register (address 1) reads all ones, the select register (address 2) reads zero, the pull register (address 3) reads zero, and `pad_oe` is all zero.
- R2: A direction bit of 0 makes the pin an output. One cycle after the register write, `pad_oe` is 1 and `pad_out` carries the latch for a push-pull pin. A written direction value reads back unchanged.
- R3: For a pin whose direction bit is 1, a read of address 0 returns the pad level once the pad has been stable for three clock edges before the read edge.
- R4: For a pin whose direction bit is 0, a read of address 0 returns the latch contents, even when the pad carries the opposite level.
- R5: On a pin set in `OD_MASK`, the pad is enabled only when the selected output value is 0. `pad_out` is then 0. A value of 1 leaves `pad_oe` at 0.
- R6: On an output pin whose select bit (address 2) is 1, `pad_out` follows `alt_out` with one register of delay. A read of address 0 still returns the latch.
- R7: A pin whose direction bit is 1 keeps `pad_oe` at 0 whether or not its select bit is set.
- R8: `alt_in` equals the pad level delayed by two clock edges, on both input and output pins.
- R9: `pad_pu` equals the pull register (address 3) one cycle after a write, and that register reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address: 0 value, 1 direction, 2 select, 3 pull |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data, registered on the read strobe |
| pad_in | input | NPINS | Level seen at each pad |
| pad_out | output | NPINS | Value driven on each pad |
| pad_oe | output | NPINS | Pad drive enable, 1 = driving |
| pad_pu | output | NPINS | Pull-up enable per pad |
| alt_out | input | NPINS | Peripheral outputs that can take over a pin |
| alt_in | output | NPINS | Retimed pad levels sent to peripherals |

## Verification
The assertions assume that `bus_wr` and `bus_rd` never rise together, and that `bus_addr` and `bus_wdata` are stable at the edge that samples a strobe. The bench drives every input on the falling clock edge and raises only one strobe per task. The assertions also take `pad_in` as an asynchronous level that may change at any time. The bench holds a new pad value for at least three edges before any read, so the two-flop retiming has settled whenever a result is compared.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_VAL  = 2'd0,
    REG_DIR  = 2'd1,
    REG_SEL  = 2'd2,
    REG_PULL = 2'd3
  } gpio_reg_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int NPINS  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] raw_i,
  output logic [NPINS-1:0] sync_o
);
  logic [NPINS-1:0] chain_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
    end else begin
      chain_q[0] <= raw_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign sync_o = chain_q[STAGES-1];

  // count edges since reset so the delay check never reaches before reset
  logic [1:0] warm_q;
  always_ff @(posedge clk) begin
    if (rst) warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  generate
    if (STAGES == 2) begin : g_chk
      p_delay_two_r8: assert property (@(posedge clk) disable iff (rst)
        (warm_q >= 2'd2) |-> (sync_o == $past(raw_i, 2)));
    end
  endgenerate
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NPINS-1:0]  wdata_i,
  input  logic [NPINS-1:0]  pin_sync_i,
  output logic [NPINS-1:0]  rdata_o,
  output logic [NPINS-1:0]  latch_o,
  output logic [NPINS-1:0]  dir_o,
  output logic [NPINS-1:0]  sel_o,
  output logic [NPINS-1:0]  pull_o
);
  logic [NPINS-1:0] latch_q, dir_q, sel_q, pull_q, rdata_q;
  logic [NPINS-1:0] val_view;

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '1;
      dir_q   <= '1;
      sel_q   <= '0;
      pull_q  <= '0;
    end else if (wr_i) begin
      unique case (gpio_reg_e'(addr_i))
        REG_VAL:  latch_q <= wdata_i;
        REG_DIR:  dir_q   <= wdata_i;
        REG_SEL:  sel_q   <= wdata_i;
        REG_PULL: pull_q  <= wdata_i;
        default:  ;
      endcase
    end
  end

  // inputs show the pad, outputs show the latch
  always_comb val_view = (dir_q & pin_sync_i) | (~dir_q & latch_q);

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (rd_i) begin
      unique case (gpio_reg_e'(addr_i))
        REG_VAL:  rdata_q <= val_view;
        REG_DIR:  rdata_q <= dir_q;
        REG_SEL:  rdata_q <= sel_q;
        REG_PULL: rdata_q <= pull_q;
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign rdata_o = rdata_q;
  assign latch_o = latch_q;
  assign dir_o   = dir_q;
  assign sel_o   = sel_q;
  assign pull_o  = pull_q;

  p_reset_dir_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (dir_q == '1 && sel_q == '0 && pull_q == '0));
  p_dir_write_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_i && addr_i == REG_DIR) |=> (dir_q == $past(wdata_i)));
  p_out_reads_latch_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_i && addr_i == REG_VAL) |=> (((rdata_o ^ $past(latch_q)) & ~$past(dir_q)) == '0));
  p_pull_write_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_i && addr_i == REG_PULL) |=> (pull_q == $past(wdata_i)));
endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl #(
  parameter int               NPINS   = 8,
  parameter logic [NPINS-1:0] OD_MASK = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] latch_i,
  input  logic [NPINS-1:0] dir_i,
  input  logic [NPINS-1:0] sel_i,
  input  logic [NPINS-1:0] pull_i,
  input  logic [NPINS-1:0] alt_out_i,
  output logic [NPINS-1:0] pad_out_o,
  output logic [NPINS-1:0] pad_oe_o,
  output logic [NPINS-1:0] pad_pu_o
);
  genvar i;
  generate
    for (i = 0; i < NPINS; i++) begin : g_pin
      logic src, out_d, oe_d, out_q, oe_q, pu_q;

      assign src = (sel_i[i] && !dir_i[i]) ? alt_out_i[i] : latch_i[i];

      if (OD_MASK[i]) begin : g_od
        assign out_d = 1'b0;
        assign oe_d  = !dir_i[i] && !src;
      end else begin : g_pp
        assign out_d = src;
        assign oe_d  = !dir_i[i];
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          out_q <= 1'b1;
          oe_q  <= 1'b0;
          pu_q  <= 1'b0;
        end else begin
          out_q <= out_d;
          oe_q  <= oe_d;
          pu_q  <= pull_i[i];
        end
      end

      assign pad_out_o[i] = out_q;
      assign pad_oe_o[i]  = oe_q;
      assign pad_pu_o[i]  = pu_q;

      p_input_floats_r7: assert property (@(posedge clk) disable iff (rst)
        oe_q |-> !$past(dir_i[i]));
      p_od_release_r5: assert property (@(posedge clk) disable iff (rst)
        (OD_MASK[i] && oe_q) |->
          (!out_q && !(($past(sel_i[i]) ? $past(alt_out_i[i]) : $past(latch_i[i])))));
      p_alt_follow_r6: assert property (@(posedge clk) disable iff (rst)
        (!OD_MASK[i] && $past(sel_i[i]) && !$past(dir_i[i])) |-> (out_q == $past(alt_out_i[i])));
    end
  endgenerate
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int               NPINS   = 8,
  parameter int               STAGES  = 2,
  parameter logic [NPINS-1:0] OD_MASK = 8'h80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pad_pu,
  input  logic [NPINS-1:0]  alt_out,
  output logic [NPINS-1:0]  alt_in
);
  logic [NPINS-1:0] pin_sync, latch, dir, sel, pull;

  gpio_sync #(.NPINS(NPINS), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst(rst), .raw_i(pad_in), .sync_o(pin_sync)
  );

  gpio_regs #(.NPINS(NPINS)) u_regs (
    .clk(clk), .rst(rst), .wr_i(bus_wr), .rd_i(bus_rd), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .pin_sync_i(pin_sync), .rdata_o(bus_rdata),
    .latch_o(latch), .dir_o(dir), .sel_o(sel), .pull_o(pull)
  );

  gpio_pad_ctl #(.NPINS(NPINS), .OD_MASK(OD_MASK)) u_pad (
    .clk(clk), .rst(rst), .latch_i(latch), .dir_i(dir), .sel_i(sel),
    .pull_i(pull), .alt_out_i(alt_out), .pad_out_o(pad_out),
    .pad_oe_o(pad_oe), .pad_pu_o(pad_pu)
  );

  // peripherals see the retimed pad level whatever the direction
  assign alt_in = pin_sync;

  p_strobes_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_rd));
endmodule

// File: tb/sim_gpio_port.sv
module sim_gpio_port;
  logic       clk = 0, rst = 1, bus_wr = 0, bus_rd = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, pad_in = 0, alt_out = 0;
  logic [7:0] bus_rdata, pad_out, pad_oe, pad_pu, alt_in;
  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_port u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
    .alt_out(alt_out), .alt_in(alt_in)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic set_pad(input logic [7:0] v);
    @(negedge clk); pad_in = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R1 oe", pad_oe, 8'h00);
    check("R9 pu at reset", pad_pu, 8'h00);
    rd(1, d); check("R1 dir", d, 8'hFF);
    rd(2, d); check("R1 sel", d, 8'h00);
    rd(3, d); check("R1 pull", d, 8'h00);
    set_pad(8'hA5);
    rd(0, d); check("R3 input read", d, 8'hA5);
  endtask

  task automatic t_output;
    logic [7:0] d;
    wr(0, 8'h3C); wr(1, 8'h00);
    rd(1, d); check("R2 dir readback", d, 8'h00);
    check("R2 oe", pad_oe, 8'hFF);
    check("R2 out", pad_out, 8'h3C);
    set_pad(8'hC3);
    rd(0, d); check("R4 latch read", d, 8'h3C);
    wr(0, 8'hBC);
    check("R5 od release oe", pad_oe, 8'h7F);
    check("R5 od out", pad_out, 8'h3C);
  endtask

  task automatic t_mixed;
    logic [7:0] d;
    wr(1, 8'hF0);
    set_pad(8'h5A);
    rd(0, d); check("R3 R4 mixed read", d, 8'h5C);
    check("R2 mixed oe", pad_oe, 8'h0F);
  endtask

  task automatic t_alt;
    logic [7:0] d;
    wr(0, 8'h00); wr(1, 8'h00);
    @(negedge clk); alt_out = 8'h05;
    wr(2, 8'h0F);
    check("R6 alt out", pad_out, 8'h05);
    check("R6 oe", pad_oe, 8'hFF);
    rd(0, d); check("R6 read latch", d, 8'h00);
    @(negedge clk); alt_out = 8'h0A;
    @(negedge clk); check("R6 alt follow", pad_out, 8'h0A);
    wr(1, 8'h0F);
    check("R7 alt on input", pad_oe, 8'hF0);
    wr(1, 8'h00); wr(2, 8'h80);
    @(negedge clk); alt_out = 8'h80;
    repeat (2) @(negedge clk);
    check("R5 od alt high", pad_oe, 8'h7F);
    @(negedge clk); alt_out = 8'h00;
    repeat (2) @(negedge clk);
    check("R5 od alt low", pad_oe, 8'hFF);
  endtask

  task automatic t_altin;
    set_pad(8'h96);
    check("R8 alt_in output pins", alt_in, 8'h96);
    wr(1, 8'hFF);
    set_pad(8'h69);
    check("R8 alt_in input pins", alt_in, 8'h69);
  endtask

  task automatic t_pull;
    logic [7:0] d;
    wr(3, 8'hA5);
    check("R9 pu", pad_pu, 8'hA5);
    rd(3, d); check("R9 readback", d, 8'hA5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset; t_output; t_mixed; t_alt; t_altin; t_pull;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule